// File: doc/BRIEF.md
# Carrier-Gated Serial Byte Framer with Three-Wire Output

This block sits behind an FSK receiver front end. It takes two raw inputs: the demodulated serial bit line, and a level that says whether signal energy is present in the band. First it turns the raw presence level into a qualified carrier flag, using a persistence timer in both directions. While the carrier is qualified, it recovers asynchronous characters from the bit line. Each character is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every good byte is then handed out on a three-wire port made of a clock, a data line and an active-low ready strobe.

A mode pin chooses who drives the port clock. With the mode pin low, the block is self-clocked: it emits an eight-pulse clock burst and then a low ready pulse. With the mode pin high, the block is host-clocked: it parks the byte in a shift register and pulls ready low. An external controller then clocks the bits out.

There is no back-pressure anywhere in the path. A byte is presented once. In host-clocked mode the next good character overwrites the shift register, so the controller must finish shifting within one character time. The bit period and the persistence time are derived from parameters for the system clock frequency, the bit rate and the hold time in microseconds.

Top module: `fsk_byte_port`

## Requirements
- R1: `carrier_n_o` goes low only after `sig_present_i` has been high for the hold time without a break. A shorter high spell leaves it high.
- R2: Once low, `carrier_n_o` returns high only after `sig_present_i` has been low for longer than the hold time. Shorter dropouts leave it low.
- R3: While the carrier is not qualified, characters on `bit_line_i` are ignored, and no byte is ever delivered for them.
- R4: With `mode_i` = 0 and the carrier not qualified, `port_clk_o`, `port_data_o` and `port_rdy_n_o` are all held at 1.
- R5: With `mode_i` = 0, each good character produces exactly 8 rising edges on `port_clk_o`, one bit period apart. The rising edge falls in the middle of a bit-period window in which `port_data_o` carries data bit k. The bits come in order k = 0..7, LSB first. No edges appear for the start or stop bit.
- R6: With `mode_i` = 0, after the eighth clock pulse `port_rdy_n_o` gives one low pulse lasting half a bit period.
- R7: A start bit is accepted only if the line, after a falling edge, is still low half a bit period later. A low glitch shorter than that produces no byte.
- R8: A character whose stop bit samples low is discarded. It produces no clock burst and no ready pulse, and the next good character is delivered normally.
- R9: With `mode_i` = 1, a good byte pulls `port_rdy_n_o` low and puts bit 0 on `port_data_o`. After the k-th rising edge of `host_clk_i`, `port_data_o` carries bit k. Ready returns high on the first edge, and `port_clk_o` stays at 1 throughout.
- R10: With `mode_i` = 1 and the carrier not qualified, nothing is loaded and `port_rdy_n_o` stays at 1.
- R11: After reset, `carrier_n_o`, `port_clk_o`, `port_data_o` and `port_rdy_n_o` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_present_i | input | 1 | Raw in-band energy indication, asynchronous |
| bit_line_i | input | 1 | Demodulated serial bit stream, asynchronous, idle high |
| mode_i | input | 1 | 0: self-clocked port, 1: host-clocked port |
| host_clk_i | input | 1 | Shift clock from the controller in host-clocked mode |
| carrier_n_o | output | 1 | Qualified carrier flag, active low |
| port_clk_o | output | 1 | Generated clock burst in self-clocked mode, otherwise 1 |
| port_data_o | output | 1 | Serial byte data |
| port_rdy_n_o | output | 1 | Byte-ready strobe, active low |

## Verification
The bench attacks the carrier timer with a presence spell just short of the hold time, and with a short dropout. A timer that does not restart on each disagreement, or that has no hysteresis, would change the flag in the wrong place. It sends a sub-half-bit glitch and a character with a low stop bit. A framer without the start re-check or the stop check would put out a phantom byte, which the scoreboard catches as a ready pulse it did not expect. It checks the burst edge count, the per-edge data and the ready width on back-to-back 0x00/0xFF/alternating bytes, where an off-by-one bit counter or a reversed shift shows at once. In host-clocked mode it checks that ready is withheld without a carrier, and that each external edge advances exactly one bit.

// File: rtl/fsk_port_pkg.sv
package fsk_port_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_BITS,
    TX_READY
  } tx_state_e;

  function automatic int unsigned cycles_per_bit(int unsigned clk_hz, int unsigned baud_hz);
    return clk_hz / baud_hz;
  endfunction

  function automatic int unsigned hold_cycles(int unsigned clk_hz, int unsigned hold_us);
    return ((clk_hz / 1000) * hold_us) / 1000;
  endfunction

endpackage

// File: rtl/fsk_carrier_qual.sv
module fsk_carrier_qual #(
  parameter int unsigned HOLD_CYC = 96000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present_i,
  output logic carrier_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 2);

  logic [1:0]    pres_s;
  logic          active_q;
  logic [CW-1:0] run_q;

  // run_q counts consecutive cycles in which the synchronised level
  // disagrees with the current flag; any agreement restarts it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_s   <= '0;
      active_q <= 1'b0;
      run_q    <= '0;
    end else begin
      pres_s <= {pres_s[0], present_i};
      if (pres_s[1] == active_q) begin
        run_q <= '0;
      end else if (!active_q && run_q == CW'(HOLD_CYC - 1)) begin
        active_q <= 1'b1;
        run_q    <= '0;
      end else if (active_q && run_q == CW'(HOLD_CYC)) begin
        active_q <= 1'b0;
        run_q    <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign carrier_o = active_q;

  p_assert_needs_presence_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(pres_s[1]));
  p_release_needs_absence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> !$past(pres_s[1]));
  p_run_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(HOLD_CYC));

endmodule

// File: rtl/fsk_char_rx.sv
module fsk_char_rx
  import fsk_port_pkg::*;
#(
  parameter int unsigned BIT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_i,
  input  logic       line_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  localparam int unsigned HALF = BIT_CYC / 2;
  localparam int unsigned CW   = $clog2(BIT_CYC + 1);

  logic [1:0]    line_s;
  logic          line_prev;
  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_s     <= 2'b11;
      line_prev  <= 1'b1;
      st         <= RX_IDLE;
      cnt        <= '0;
      nbit       <= '0;
      sh         <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      line_s     <= {line_s[0], line_i};
      line_prev  <= line_s[1];
      byte_vld_o <= 1'b0;
      if (!carrier_i) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          RX_IDLE: begin
            if (line_prev && !line_s[1]) begin
              st  <= RX_START;
              cnt <= CW'(1);
            end
          end
          RX_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt  <= '0;
              nbit <= '0;
              st   <= line_s[1] ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CW'(BIT_CYC - 1)) begin
              cnt  <= '0;
              sh   <= {line_s[1], sh[7:1]};
              nbit <= nbit + 1'b1;
              if (nbit == 3'd7) st <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == CW'(BIT_CYC - 1)) begin
              cnt        <= '0;
              byte_vld_o <= line_s[1];
              st         <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = sh;

  p_quiet_without_carrier_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_i |=> (st == RX_IDLE && !byte_vld_o));
  p_byte_only_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> ($past(st) == RX_STOP && $past(line_s[1])));
  p_start_recheck_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_DATA && $past(st) == RX_START) |-> !$past(line_s[1]));

endmodule

// File: rtl/fsk_port_out.sv
module fsk_port_out
  import fsk_port_pkg::*;
#(
  parameter int unsigned BIT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_i,
  input  logic       mode_i,
  input  logic       host_clk_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       port_clk_o,
  output logic       port_data_o,
  output logic       port_rdy_n_o
);
  localparam int unsigned HALF = BIT_CYC / 2;
  localparam int unsigned CW   = $clog2(BIT_CYC + 1);

  tx_state_e     st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    hold_q;
  logic [1:0]    hclk_s;
  logic          hclk_prev;
  logic          hrise;

  assign hrise = hclk_s[1] & ~hclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= TX_IDLE;
      cnt          <= '0;
      idx          <= '0;
      hold_q       <= '1;
      hclk_s       <= '0;
      hclk_prev    <= 1'b0;
      port_clk_o   <= 1'b1;
      port_data_o  <= 1'b1;
      port_rdy_n_o <= 1'b1;
    end else begin
      hclk_s    <= {hclk_s[0], host_clk_i};
      hclk_prev <= hclk_s[1];
      if (!carrier_i) begin
        st           <= TX_IDLE;
        cnt          <= '0;
        port_clk_o   <= 1'b1;
        port_data_o  <= 1'b1;
        port_rdy_n_o <= 1'b1;
      end else if (!mode_i) begin
        unique case (st)
          TX_IDLE: begin
            port_clk_o   <= 1'b1;
            port_data_o  <= 1'b1;
            port_rdy_n_o <= 1'b1;
            if (byte_vld_i) begin
              hold_q      <= byte_i;
              port_data_o <= byte_i[0];
              port_clk_o  <= 1'b0;
              idx         <= '0;
              cnt         <= '0;
              st          <= TX_BITS;
            end
          end
          TX_BITS: begin
            if (cnt == CW'(HALF - 1)) port_clk_o <= 1'b1;
            if (cnt == CW'(BIT_CYC - 1)) begin
              cnt <= '0;
              if (idx == 3'd7) begin
                st           <= TX_READY;
                port_rdy_n_o <= 1'b0;
                port_data_o  <= 1'b1;
              end else begin
                idx         <= idx + 3'd1;
                port_data_o <= hold_q[idx + 3'd1];
                port_clk_o  <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          TX_READY: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt          <= '0;
              port_rdy_n_o <= 1'b1;
              st           <= TX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= TX_IDLE;
        endcase
      end else begin
        st         <= TX_IDLE;
        cnt        <= '0;
        port_clk_o <= 1'b1;
        if (byte_vld_i) begin
          hold_q       <= byte_i;
          port_data_o  <= byte_i[0];
          port_rdy_n_o <= 1'b0;
        end else if (hrise) begin
          hold_q       <= {1'b1, hold_q[7:1]};
          port_data_o  <= hold_q[1];
          port_rdy_n_o <= 1'b1;
        end
      end
    end
  end

  p_idle_lines_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_i && !mode_i) |=> (port_clk_o && port_data_o && port_rdy_n_o));
  p_ready_withheld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_i |=> port_rdy_n_o);
  p_ready_after_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(port_rdy_n_o) && !mode_i && !$past(mode_i)) |-> (port_clk_o && $past(port_clk_o)));
  p_host_mode_clk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && $past(mode_i)) |-> port_clk_o);

endmodule

// File: rtl/fsk_byte_port.sv
module fsk_byte_port
  import fsk_port_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 12_000_000,
  parameter int unsigned BAUD_HZ = 1200,
  parameter int unsigned HOLD_US = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_present_i,
  input  logic bit_line_i,
  input  logic mode_i,
  input  logic host_clk_i,
  output logic carrier_n_o,
  output logic port_clk_o,
  output logic port_data_o,
  output logic port_rdy_n_o
);
  localparam int unsigned BIT_CYC  = cycles_per_bit(CLK_HZ, BAUD_HZ);
  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_US);

  logic       carrier;
  logic       byte_vld;
  logic [7:0] byte_val;

  fsk_carrier_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .present_i (sig_present_i),
    .carrier_o (carrier)
  );

  fsk_char_rx #(.BIT_CYC(BIT_CYC)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_i  (carrier),
    .line_i     (bit_line_i),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val)
  );

  fsk_port_out #(.BIT_CYC(BIT_CYC)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_i    (carrier),
    .mode_i       (mode_i),
    .host_clk_i   (host_clk_i),
    .byte_vld_i   (byte_vld),
    .byte_i       (byte_val),
    .port_clk_o   (port_clk_o),
    .port_data_o  (port_data_o),
    .port_rdy_n_o (port_rdy_n_o)
  );

  assign carrier_n_o = ~carrier;

endmodule

// File: tb/fsk_byte_port_test.sv
`timescale 1ns/1ps
module fsk_byte_port_test;
  localparam int BIT  = 16;
  localparam int HALF = 8;
  localparam int HOLD = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_present = 1'b0;
  logic bit_line = 1'b1;
  logic mode = 1'b0;
  logic host_clk = 1'b0;
  logic carrier_n, pclk, pdata, prdy_n;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  fsk_byte_port #(.CLK_HZ(1_600_000), .BAUD_HZ(100_000), .HOLD_US(40)) uut (
    .clk(clk), .rst_n(rst_n), .sig_present_i(sig_present), .bit_line_i(bit_line),
    .mode_i(mode), .host_clk_i(host_clk), .carrier_n_o(carrier_n),
    .port_clk_o(pclk), .port_data_o(pdata), .port_rdy_n_o(prdy_n));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    bit_line = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input bit stop_ok, input bit expect_out);
    if (expect_out) exp_q.push_back(b);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop_ok);
    bit_line = 1'b1;
  endtask

  // Scoreboard monitor for the self-clocked port (R5, R6, R3, R8, R4)
  logic prev_clk = 1'b1, prev_rdy = 1'b1, prev_cdn = 1'b1;
  int   nrise = 0, lowcnt = 0;
  logic [7:0] acc = '0;
  bit   rdy_low_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prdy_n) rdy_low_seen = 1'b1;
      if (!mode) begin
        if (carrier_n && prev_cdn)
          check(pclk && pdata && prdy_n, "R4", "lines high without carrier",
                {pclk, pdata, prdy_n}, 3'b111);
        if (!prev_clk && pclk) begin
          acc = {pdata, acc[7:1]};
          nrise++;
        end
        if (prev_rdy && !prdy_n) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3/R8", "unexpected ready pulse", acc, 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(nrise == 8, "R5", "clock edges per byte", nrise, 8);
            check(acc == e, "R5", "byte on data line", acc, e);
          end
          nrise = 0;
          lowcnt = 0;
        end
        if (!prdy_n) lowcnt++;
        if (!prev_rdy && prdy_n)
          check(lowcnt == HALF, "R6", "ready pulse width", lowcnt, HALF);
      end
      prev_clk = pclk;
      prev_rdy = prdy_n;
      prev_cdn = carrier_n;
    end
  end

  task automatic host_pulse();
    host_clk = 1'b1;
    idle(6);
    host_clk = 1'b0;
    idle(6);
  endtask

  task automatic host_read(input logic [7:0] e);
    int guard;
    guard = 0;
    while (prdy_n && guard < 400) begin
      idle(1);
      guard++;
    end
    check(!prdy_n, "R9", "ready low for loaded byte", prdy_n, 0);
    check(pdata == e[0], "R9", "bit 0 after load", pdata, e[0]);
    for (int k = 1; k < 8; k++) begin
      host_pulse();
      if (k == 1) check(prdy_n, "R9", "ready released on first edge", prdy_n, 1);
      check(pdata == e[k], "R9", $sformatf("bit %0d after edge", k), pdata, e[k]);
      check(pclk, "R9", "port clock idle in host mode", pclk, 1);
    end
    host_pulse();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(4);
    check(carrier_n && pclk && pdata && prdy_n, "R11", "reset outputs",
          {carrier_n, pclk, pdata, prdy_n}, 4'hf);
    rst_n = 1'b1;
    idle(4);
    check(carrier_n && pclk && pdata && prdy_n, "R11", "outputs after reset",
          {carrier_n, pclk, pdata, prdy_n}, 4'hf);

    // R3/R4: characters without carrier are ignored
    send_char(8'h55, 1'b1, 1'b0);
    idle(20);
    check(pclk && pdata && prdy_n, "R4", "no activity without carrier",
          {pclk, pdata, prdy_n}, 3'b111);

    // R1: short presence does not qualify
    sig_present = 1'b1;
    idle(HOLD - 8);
    sig_present = 1'b0;
    idle(100);
    check(carrier_n, "R1", "short presence rejected", carrier_n, 1);

    // R1: long presence qualifies
    sig_present = 1'b1;
    idle(HOLD + 10);
    check(!carrier_n, "R1", "carrier qualified", carrier_n, 0);

    // R5/R6: back-to-back bytes
    send_char(8'hA5, 1'b1, 1'b1);
    send_char(8'h3C, 1'b1, 1'b1);
    send_char(8'h00, 1'b1, 1'b1);
    send_char(8'hFF, 1'b1, 1'b1);
    idle(12 * BIT);

    // R7: sub-half-bit glitch, then a real byte
    bit_line = 1'b0;
    idle(4);
    bit_line = 1'b1;
    idle(3 * BIT);
    send_char(8'h81, 1'b1, 1'b1);
    idle(12 * BIT);

    // R8: framing error discarded, next byte fine
    send_char(8'h77, 1'b0, 1'b0);
    idle(2 * BIT);
    send_char(8'h12, 1'b1, 1'b1);
    idle(12 * BIT);

    // R2: short dropout ignored
    sig_present = 1'b0;
    idle(30);
    sig_present = 1'b1;
    idle(HOLD + 20);
    check(!carrier_n, "R2", "carrier held over dropout", carrier_n, 0);
    send_char(8'h69, 1'b1, 1'b1);
    idle(12 * BIT);
    check(exp_q.size() == 0, "R5", "all expected bytes delivered", exp_q.size(), 0);

    // R2: long absence releases
    sig_present = 1'b0;
    idle(HOLD - 6);
    check(!carrier_n, "R2", "carrier kept before hold time", carrier_n, 0);
    idle(20);
    check(carrier_n, "R2", "carrier released", carrier_n, 1);

    // R10: host mode without carrier
    mode = 1'b1;
    idle(4);
    rdy_low_seen = 1'b0;
    send_char(8'h5A, 1'b1, 1'b0);
    idle(3 * BIT);
    check(!rdy_low_seen, "R10", "ready withheld without carrier", rdy_low_seen, 0);

    // R9: host-clocked transfer
    sig_present = 1'b1;
    idle(HOLD + 20);
    check(!carrier_n, "R9", "carrier for host transfer", carrier_n, 0);
    fork
      send_char(8'hC3, 1'b1, 1'b0);
      host_read(8'hC3);
    join
    idle(BIT);
    fork
      send_char(8'h2D, 1'b1, 1'b0);
      host_read(8'h2D);
    join
    idle(BIT);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule